// File: doc/BRIEF.md
# Script Instruction Fetch Sequencer

This block is the front end of a small script processor. The host loads a start address into the script pointer, and the block begins to run. For each instruction it reads two consecutive 32-bit words from memory and decodes the opcode in the top byte of the first word. A data-move instruction hands a byte count and a target address to a separate transfer engine. The block waits for that engine to finish and then fetches the next instruction at the advanced pointer.

Execution runs until an interrupt opcode appears or an error occurs. The error can be a failed memory response, a failed transfer, or an opcode the block does not define. The block then raises its host interrupt line and stays halted until the host acts. The host has two ways out of the halt. It can write a new pointer, which also clears the interrupt and restarts execution. It can also write the clear bit, which leaves the pointer alone and puts the block in idle.

Top module: `script_fetch_seq`

## Requirements
- R1: After reset, host_ptr is 0 and irq, irq_err, busy, mem_req and mv_start are all 0.
- R2: When the block is idle or halted, a pointer write (host_we=1, host_sel=0) loads host_wdata into host_ptr. In the next cycle, mem_req is 1 with mem_addr equal to the written value, and irq and irq_err are 0.
- R3: Each instruction is read as two requests, first at host_ptr and then at host_ptr+4. Only one request is outstanding at a time, and a request ends with the mem_rvalid pulse that answers it.
- R4: Bits [31:24] of the first word select the operation: 8'h01 is a data move, 8'h02 is an interrupt, and 8'h00 is a no-op. Any other value is an undefined opcode.
- R5: For a data move with a non-zero count, mv_count equals bits [23:0] of the first word and mv_addr equals the second word. mv_start stays at 1, with both values stable, until the cycle in which mv_done is 1.
- R6: A data move whose count is zero does not raise mv_start, and the block goes straight on to the next fetch.
- R7: Each completed two-word fetch adds 8 to host_ptr, wrapping modulo 2^32. After a no-op, or after a move that ends without error, the next fetch starts at the advanced pointer.
- R8: An interrupt opcode halts the block with irq=1 and irq_err=0, and host_ptr points past that instruction.
- R9: The block halts with irq=1 and irq_err=1 in three cases: an undefined opcode, a memory response with mem_err=1, or mv_done together with mv_err=1. After a memory error, host_ptr is left at the instruction that failed.
- R10: While halted, mem_req and mv_start stay at 0 until the host writes.
- R11: A control write (host_we=1, host_sel=1) with host_wdata[0]=1, made while halted, clears irq and irq_err and moves the block to idle. host_ptr does not change. A control write with host_wdata[0]=0 has no effect.
- R12: A pointer write while busy=1 is ignored, and execution carries on unchanged. busy is 1 from the first fetch until the halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_we | input | 1 | Host write strobe |
| host_sel | input | 1 | 0: pointer register, 1: control register |
| host_wdata | input | 32 | Host write data |
| host_ptr | output | 32 | Current script pointer |
| busy | output | 1 | Executing a script |
| irq | output | 1 | Host interrupt |
| irq_err | output | 1 | Interrupt caused by an error |
| mem_req | output | 1 | Memory read request, held until answered |
| mem_addr | output | 32 | Memory read address |
| mem_rvalid | input | 1 | Response valid |
| mem_rdata | input | 32 | Response data |
| mem_err | input | 1 | Response carries an error |
| mv_start | output | 1 | Transfer request to the data engine |
| mv_count | output | 24 | Byte count for the transfer |
| mv_addr | output | 32 | Start address for the transfer |
| mv_done | input | 1 | Transfer finished |
| mv_err | input | 1 | Transfer failed (valid with mv_done) |

## Verification
The bench runs one instruction for every one of the 256 opcode values. Each instruction is followed by an interrupt instruction, and the memory latency is varied from run to run. This sweep separates the four decode outcomes by looking at the final pointer, the error flag and whether a transfer took place. Separate scripts cover the remaining cases: a chain of moves and no-ops, a zero-count move, memory errors on each of the two words, a failed transfer, and a pointer that wraps at the top of the address space. Further runs check that a pointer write is ignored while a script runs, and that a clear write with bit 0 at 1 and at 0 behaves as required, with the pointer left unchanged.

// File: rtl/sfs_pkg.sv
package sfs_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH_LO,
        S_FETCH_HI,
        S_MOVE,
        S_HALT
    } seq_state_e;

    typedef enum logic [1:0] {
        K_NOP,
        K_MOVE,
        K_INT,
        K_BAD
    } op_kind_e;

    localparam int OP_W = 8;

endpackage

// File: rtl/sfs_decode.sv
module sfs_decode
    import sfs_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter logic [OP_W-1:0] OPC_NOP  = 8'h00,
    parameter logic [OP_W-1:0] OPC_MOVE = 8'h01,
    parameter logic [OP_W-1:0] OPC_INT  = 8'h02,
    localparam int CNT_W = WORD_W - OP_W
) (
    input  logic [WORD_W-1:0] word,
    output op_kind_e          kind,
    output logic [CNT_W-1:0]  count,
    output logic              count_zero
);

    logic [OP_W-1:0] opc;

    always_comb begin
        opc        = word[WORD_W-1 -: OP_W];
        count      = word[CNT_W-1:0];
        count_zero = (count == '0);
        if (opc == OPC_MOVE)      kind = K_MOVE;
        else if (opc == OPC_INT)  kind = K_INT;
        else if (opc == OPC_NOP)  kind = K_NOP;
        else                      kind = K_BAD;
    end

endmodule

// File: rtl/sfs_ptr.sv
module sfs_ptr #(
    parameter int ADDR_W     = 32,
    parameter int WORD_BYTES = 4,
    localparam int INSTR_BYTES = 2 * WORD_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              adv,
    output logic [ADDR_W-1:0] ptr,
    output logic [ADDR_W-1:0] ptr_hi
);

    logic [ADDR_W-1:0] ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (load)      ptr_d = load_val;
        else if (adv)  ptr_d = ptr_q + ADDR_W'(INSTR_BYTES);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign ptr    = ptr_q;
    assign ptr_hi = ptr_q + ADDR_W'(WORD_BYTES);

endmodule

// File: rtl/sfs_seq.sv
module sfs_seq
    import sfs_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int WORD_W = 32,
    localparam int CNT_W = WORD_W - OP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ptr_wr,
    input  logic              ctl_wr,
    input  logic              clr_bit,
    input  logic              mem_rvalid,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_err,
    input  op_kind_e          dec_kind,
    input  logic [CNT_W-1:0]  dec_count,
    input  logic              dec_zero,
    input  logic              mv_done,
    input  logic              mv_err,
    output logic [WORD_W-1:0] word0,
    output logic              ptr_load,
    output logic              ptr_adv,
    output logic              fetch_hi,
    output logic              mem_req,
    output logic              mv_start,
    output logic [CNT_W-1:0]  mv_count,
    output logic [ADDR_W-1:0] mv_addr,
    output logic              irq,
    output logic              irq_err,
    output logic              busy
);

    typedef struct packed {
        seq_state_e        state;
        logic [WORD_W-1:0] w0;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic              irq;
        logic              err;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        ptr_load = 1'b0;
        ptr_adv  = 1'b0;
        unique case (r_q.state)
            S_IDLE: begin
                if (ptr_wr) begin
                    ptr_load  = 1'b1;
                    r_d.state = S_FETCH_LO;
                end
            end
            S_FETCH_LO: begin
                if (mem_rvalid) begin
                    if (mem_err) begin
                        r_d.state = S_HALT;
                        r_d.irq   = 1'b1;
                        r_d.err   = 1'b1;
                    end else begin
                        r_d.w0    = mem_rdata;
                        r_d.state = S_FETCH_HI;
                    end
                end
            end
            S_FETCH_HI: begin
                if (mem_rvalid) begin
                    if (mem_err) begin
                        r_d.state = S_HALT;
                        r_d.irq   = 1'b1;
                        r_d.err   = 1'b1;
                    end else begin
                        ptr_adv = 1'b1;
                        unique case (dec_kind)
                            K_MOVE: begin
                                r_d.cnt   = dec_count;
                                r_d.addr  = ADDR_W'(mem_rdata);
                                r_d.state = dec_zero ? S_FETCH_LO : S_MOVE;
                            end
                            K_NOP: r_d.state = S_FETCH_LO;
                            K_INT: begin
                                r_d.state = S_HALT;
                                r_d.irq   = 1'b1;
                            end
                            default: begin
                                r_d.state = S_HALT;
                                r_d.irq   = 1'b1;
                                r_d.err   = 1'b1;
                            end
                        endcase
                    end
                end
            end
            S_MOVE: begin
                if (mv_done) begin
                    if (mv_err) begin
                        r_d.state = S_HALT;
                        r_d.irq   = 1'b1;
                        r_d.err   = 1'b1;
                    end else begin
                        r_d.state = S_FETCH_LO;
                    end
                end
            end
            S_HALT: begin
                if (ptr_wr) begin
                    ptr_load  = 1'b1;
                    r_d.irq   = 1'b0;
                    r_d.err   = 1'b0;
                    r_d.state = S_FETCH_LO;
                end else if (ctl_wr && clr_bit) begin
                    r_d.irq   = 1'b0;
                    r_d.err   = 1'b0;
                    r_d.state = S_IDLE;
                end
            end
            default: r_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= S_IDLE;
            r_q.w0    <= '0;
            r_q.cnt   <= '0;
            r_q.addr  <= '0;
            r_q.irq   <= 1'b0;
            r_q.err   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign word0    = r_q.w0;
    assign fetch_hi = (r_q.state == S_FETCH_HI);
    assign mem_req  = (r_q.state == S_FETCH_LO) || (r_q.state == S_FETCH_HI);
    assign mv_start = (r_q.state == S_MOVE);
    assign mv_count = r_q.cnt;
    assign mv_addr  = r_q.addr;
    assign irq      = r_q.irq;
    assign irq_err  = r_q.err;
    assign busy     = (r_q.state != S_IDLE) && (r_q.state != S_HALT);

endmodule

// File: rtl/script_fetch_seq.sv
module script_fetch_seq
    import sfs_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int WORD_W = 32,
    parameter logic [OP_W-1:0] OPC_NOP  = 8'h00,
    parameter logic [OP_W-1:0] OPC_MOVE = 8'h01,
    parameter logic [OP_W-1:0] OPC_INT  = 8'h02,
    localparam int CNT_W      = WORD_W - OP_W,
    localparam int WORD_BYTES = WORD_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic              host_sel,
    input  logic [WORD_W-1:0] host_wdata,
    output logic [ADDR_W-1:0] host_ptr,
    output logic              busy,
    output logic              irq,
    output logic              irq_err,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_err,
    output logic              mv_start,
    output logic [CNT_W-1:0]  mv_count,
    output logic [ADDR_W-1:0] mv_addr,
    input  logic              mv_done,
    input  logic              mv_err
);

    logic              ptr_wr, ctl_wr;
    logic              ptr_load, ptr_adv, fetch_hi;
    logic [ADDR_W-1:0] ptr_hi;
    logic [WORD_W-1:0] word0;
    op_kind_e          dec_kind;
    logic [CNT_W-1:0]  dec_count;
    logic              dec_zero;

    assign ptr_wr = host_we && !host_sel;
    assign ctl_wr = host_we && host_sel;

    sfs_ptr #(
        .ADDR_W     (ADDR_W),
        .WORD_BYTES (WORD_BYTES)
    ) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ptr_load),
        .load_val (ADDR_W'(host_wdata)),
        .adv      (ptr_adv),
        .ptr      (host_ptr),
        .ptr_hi   (ptr_hi)
    );

    sfs_decode #(
        .WORD_W   (WORD_W),
        .OPC_NOP  (OPC_NOP),
        .OPC_MOVE (OPC_MOVE),
        .OPC_INT  (OPC_INT)
    ) u_dec (
        .word       (word0),
        .kind       (dec_kind),
        .count      (dec_count),
        .count_zero (dec_zero)
    );

    sfs_seq #(
        .ADDR_W (ADDR_W),
        .WORD_W (WORD_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .ptr_wr     (ptr_wr),
        .ctl_wr     (ctl_wr),
        .clr_bit    (host_wdata[0]),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .mem_err    (mem_err),
        .dec_kind   (dec_kind),
        .dec_count  (dec_count),
        .dec_zero   (dec_zero),
        .mv_done    (mv_done),
        .mv_err     (mv_err),
        .word0      (word0),
        .ptr_load   (ptr_load),
        .ptr_adv    (ptr_adv),
        .fetch_hi   (fetch_hi),
        .mem_req    (mem_req),
        .mv_start   (mv_start),
        .mv_count   (mv_count),
        .mv_addr    (mv_addr),
        .irq        (irq),
        .irq_err    (irq_err),
        .busy       (busy)
    );

    assign mem_addr = fetch_hi ? ptr_hi : host_ptr;

endmodule

// File: rtl/script_fetch_seq_chk.sv
module script_fetch_seq_chk #(
    parameter int ADDR_W = 32,
    parameter int WORD_W = 32,
    parameter int CNT_W  = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_we,
    input logic              host_sel,
    input logic [WORD_W-1:0] host_wdata,
    input logic [ADDR_W-1:0] host_ptr,
    input logic              busy,
    input logic              irq,
    input logic              irq_err,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rvalid,
    input logic              mem_err,
    input logic              mv_start,
    input logic [CNT_W-1:0]  mv_count,
    input logic [ADDR_W-1:0] mv_addr,
    input logic              mv_done,
    input logic              fetch_hi
);

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |-> !irq && !busy && !mem_req && !mv_start);

    p_write_starts_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && host_we && !host_sel) |=>
            (mem_req && mem_addr == $past(ADDR_W'(host_wdata)) && !irq && !irq_err));

    p_req_or_move_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && mv_start));

    p_move_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mv_start && !mv_done) |=> (mv_start && $stable(mv_count) && $stable(mv_addr)));

    p_ptr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_hi && mem_rvalid && !mem_err) |=> (host_ptr == $past(host_ptr) + ADDR_W'(8)));

    p_mem_fault_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_rvalid && mem_err) |=> (irq && irq_err && $stable(host_ptr)));

    p_err_needs_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_err |-> irq);

    p_halt_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (!mem_req && !mv_start && !busy));

    p_clear_keeps_ptr_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && host_we && host_sel && host_wdata[0]) |=> (!irq && !irq_err && $stable(host_ptr)));

    p_busy_write_ignored_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && host_we && !host_sel && !(fetch_hi && mem_rvalid && !mem_err))
            |=> $stable(host_ptr));

endmodule

bind script_fetch_seq script_fetch_seq_chk #(
    .ADDR_W (ADDR_W),
    .WORD_W (WORD_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_we    (host_we),
    .host_sel   (host_sel),
    .host_wdata (host_wdata),
    .host_ptr   (host_ptr),
    .busy       (busy),
    .irq        (irq),
    .irq_err    (irq_err),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid),
    .mem_err    (mem_err),
    .mv_start   (mv_start),
    .mv_count   (mv_count),
    .mv_addr    (mv_addr),
    .mv_done    (mv_done),
    .fetch_hi   (fetch_hi)
);

// File: tb/script_fetch_seq_tb.sv
`timescale 1ns/1ps
module script_fetch_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic        host_sel = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_ptr;
    logic        busy, irq, irq_err, mem_req, mv_start;
    logic [31:0] mem_addr, mv_addr;
    logic [23:0] mv_count;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        mem_err = 1'b0;
    logic        mv_done = 1'b0;
    logic        mv_err = 1'b0;

    always #4 clk = ~clk;

    script_fetch_seq u_dut (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
        .host_wdata(host_wdata), .host_ptr(host_ptr), .busy(busy), .irq(irq),
        .irq_err(irq_err), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .mem_err(mem_err),
        .mv_start(mv_start), .mv_count(mv_count), .mv_addr(mv_addr),
        .mv_done(mv_done), .mv_err(mv_err)
    );

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;

    logic [31:0] mem [0:255];
    int          mem_lat = 0;
    logic        fault_en = 1'b0;
    logic [31:0] fault_addr = '0;
    int          eng_lat = 2;
    logic        eng_fail = 1'b0;
    int          n_moves = 0;
    logic [23:0] rec_cnt [0:7];
    logic [31:0] rec_addr [0:7];

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // memory responder
    initial begin
        logic        pend = 1'b0;
        int          cnt = 0;
        logic [31:0] a = '0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                pend = 1'b0; mem_rvalid = 1'b0; mem_err = 1'b0;
            end else if (mem_rvalid) begin
                mem_rvalid = 1'b0; mem_err = 1'b0; pend = 1'b0;
            end else if (pend) begin
                if (cnt == 0) begin
                    mem_rvalid = 1'b1;
                    mem_rdata  = mem[a[9:2]];
                    mem_err    = fault_en && (a == fault_addr);
                end else cnt--;
            end else if (mem_req) begin
                pend = 1'b1; a = mem_addr; cnt = mem_lat;
            end
        end
    end

    // data engine responder
    initial begin
        int c = 0;
        forever begin
            @(negedge clk);
            if (!rst_n || mv_done) begin
                mv_done = 1'b0; mv_err = 1'b0; c = 0;
            end else if (mv_start) begin
                if (c >= eng_lat) begin
                    mv_done = 1'b1; mv_err = eng_fail;
                    if (n_moves < 8) begin
                        rec_cnt[n_moves] = mv_count;
                        rec_addr[n_moves] = mv_addr;
                    end
                    n_moves++;
                    c = 0;
                end else c++;
            end
        end
    end

    task automatic host_wr(input logic sel, input logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_sel = sel; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic wait_halt(input string tag);
        int t = 0;
        while (!irq && t < 3000) begin
            @(negedge clk);
            t++;
        end
        chk(irq, tag, {31'b0, irq}, 32'h1);
    endtask

    task automatic start_at(input logic [31:0] a, input string tag);
        n_moves = 0;
        host_wr(1'b0, a);
        chk(mem_req && mem_addr == a && !irq && !irq_err, tag, mem_addr, a);
        chk(host_ptr == a, tag, host_ptr, a);
    endtask

    // watchdog
    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'h0200_0000;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(host_ptr == 0, "R1 ptr", host_ptr, 0);
        chk(!irq && !irq_err && !busy && !mem_req && !mv_start, "R1 outputs",
            {27'b0, irq, irq_err, busy, mem_req, mv_start}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // opcode sweep: R2 R3 R4 R5 R7 R8 R9
        for (int op = 0; op < 256; op++) begin
            logic [23:0] cnt;
            logic [31:0] a2, ep;
            logic        ee;
            int          em;
            cnt = {8'(op) ^ 8'hA5, 8'h3C, 8'(op)};
            a2  = 32'hA000_0000 | (32'(op) << 4);
            mem[8'h40] = {8'(op), cnt};
            mem[8'h41] = a2;
            mem[8'h42] = 32'h0200_0000;
            mem[8'h43] = 32'h0;
            mem_lat = op % 4;
            if (op % 2 == 0 && irq) begin
                host_wr(1'b1, 32'h1);
                chk(!irq && !busy, "R11 clear before run", {31'b0, irq}, 0);
            end
            start_at(32'h100, "R2 start fetch");
            em = 0; ee = 1'b0; ep = 32'h108;
            if (op == 1) begin em = 1; ep = 32'h110; end
            else if (op == 0) ep = 32'h110;
            else if (op != 2) ee = 1'b1;
            wait_halt("R8 halt in sweep");
            chk(irq_err == ee, "R4 R9 error flag", {31'b0, irq_err}, {31'b0, ee});
            chk(host_ptr == ep, "R7 ptr after sweep", host_ptr, ep);
            chk(n_moves == em, "R4 move count", n_moves, em);
            if (em == 1) begin
                chk(rec_cnt[0] == cnt, "R5 count", {8'b0, rec_cnt[0]}, {8'b0, cnt});
                chk(rec_addr[0] == a2, "R5 addr", rec_addr[0], a2);
            end
        end

        // R10 halted: silent
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            chk(!mem_req && !mv_start && irq, "R10 halted quiet", {31'b0, mem_req}, 0);
        end

        // R11 control with bit0=0 has no effect, bit0=1 clears, ptr stays
        host_wr(1'b1, 32'hFFFF_FFFE);
        chk(irq && host_ptr == 32'h108, "R11 clear bit zero ignored", host_ptr, 32'h108);
        host_wr(1'b1, 32'h1);
        chk(!irq && !irq_err && !busy && host_ptr == 32'h108, "R11 clear", host_ptr, 32'h108);
        repeat (5) @(negedge clk);
        chk(!mem_req && !irq, "R11 idle after clear", {31'b0, mem_req}, 0);

        // chain: R6 R7 R3
        mem_lat = 2; eng_lat = 5;
        mem[8'h80] = 32'h0100_0010; mem[8'h81] = 32'h0000_1000;
        mem[8'h82] = 32'h01FF_FFFF; mem[8'h83] = 32'hDEAD_BEE0;
        mem[8'h84] = 32'h0000_0000; mem[8'h85] = 32'h0;
        mem[8'h86] = 32'h0100_0000; mem[8'h87] = 32'h0000_7770;
        mem[8'h88] = 32'h0100_0001; mem[8'h89] = 32'h0000_0004;
        mem[8'h8A] = 32'h0200_0000; mem[8'h8B] = 32'h0;
        start_at(32'h200, "R2 chain start");
        wait_halt("R8 chain halt");
        chk(host_ptr == 32'h230, "R7 chain ptr", host_ptr, 32'h230);
        chk(n_moves == 3, "R6 zero count skipped", n_moves, 3);
        chk(rec_cnt[1] == 24'hFFFFFF && rec_addr[1] == 32'hDEAD_BEE0, "R5 max count",
            {8'b0, rec_cnt[1]}, 32'hFFFFFF);
        chk(rec_cnt[2] == 24'h1 && rec_addr[2] == 32'h4, "R7 resumes after move",
            {8'b0, rec_cnt[2]}, 32'h1);
        chk(!irq_err, "R8 chain no error", {31'b0, irq_err}, 0);

        // R12 pointer write ignored while running
        eng_lat = 30;
        mem[8'hC0] = 32'h0100_0020; mem[8'hC1] = 32'h0000_5000;
        mem[8'hC2] = 32'h0200_0000; mem[8'hC3] = 32'h0;
        start_at(32'h300, "R2 busy start");
        begin
            int t = 0;
            while (!mv_start && t < 200) begin @(negedge clk); t++; end
        end
        chk(busy, "R12 busy while moving", {31'b0, busy}, 1);
        host_wr(1'b0, 32'h3F0);
        chk(host_ptr == 32'h308 && mv_start, "R12 write ignored", host_ptr, 32'h308);
        wait_halt("R12 halt");
        chk(host_ptr == 32'h310 && n_moves == 1 && !irq_err, "R12 run unchanged", host_ptr, 32'h310);

        // R9 memory error on second word, then first word
        eng_lat = 2; mem_lat = 1;
        mem[8'hE0] = 32'h0100_0008; mem[8'hE1] = 32'h0000_9000;
        fault_en = 1'b1; fault_addr = 32'h384;
        start_at(32'h380, "R2 fault start");
        wait_halt("R9 fault halt");
        chk(irq_err && host_ptr == 32'h380 && n_moves == 0, "R9 second word fault", host_ptr, 32'h380);
        fault_addr = 32'h380;
        start_at(32'h380, "R2 fault start 2");
        wait_halt("R9 fault halt 2");
        chk(irq_err && host_ptr == 32'h380, "R9 first word fault", host_ptr, 32'h380);
        fault_en = 1'b0;

        // R9 transfer error
        eng_fail = 1'b1;
        mem[8'hE8] = 32'h0100_0005; mem[8'hE9] = 32'h0000_A000;
        start_at(32'h3A0, "R2 engine start");
        wait_halt("R9 engine halt");
        chk(irq_err && host_ptr == 32'h3A8 && n_moves == 1, "R9 transfer fault", host_ptr, 32'h3A8);
        eng_fail = 1'b0;

        // R7 wrap
        mem[8'hFE] = 32'h0200_0000;
        start_at(32'hFFFF_FFF8, "R2 wrap start");
        wait_halt("R8 wrap halt");
        chk(host_ptr == 32'h0 && !irq_err, "R7 wrap", host_ptr, 32'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule